// File: doc/BRIEF.md
# Two-Wire 16-Bit Register Slave

This block is a slave on a two-wire serial bus with a clock line and an open-drain data line. It gives a host access to a bank of 16-bit registers, although every bus transfer carries only eight bits. The block runs entirely on the system clock. It passes the bus clock and data lines through a synchronizer and oversamples them. It never uses the bus clock line as a clock.

A write transaction has a fixed shape. After a start condition the host sends the device address with the direction bit cleared. The next byte is a register pointer. Data bytes then follow in pairs: the upper half of the word first, the lower half second. When a pair is complete, the block emits a one-cycle write strobe carrying the pointer and the full word, and then advances the pointer. A read transaction uses the current pointer. The block requests the word from the register bank, shifts out its upper byte and then its lower byte, and moves on to the next register for as long as the host keeps acknowledging.

The data line output is a drive-low enable. Outside the block, the line is the wired AND of the host's drive and the inverse of this enable.

Top module: `twr_regslave`

## Requirements
- R1: While reset is asserted, and directly after it, `sda_drive_low`, `wr_stb` and `rd_req` are all 0.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. The first byte after a start holds a 7-bit device address in bits 7..1 and a direction bit in bit 0, where 1 means read. Bits go MSB first and are sampled on SCL rising.
- R3: When bits 7..1 of the address byte equal `DEV_ADDR`, the slave pulls SDA low through the ninth (acknowledge) clock.
- R4: In a write, the first byte after the address byte loads the register pointer and is acknowledged.
- R5: Data bytes of a write are paired, upper byte first. After the lower byte, `wr_stb` pulses for exactly one cycle, with `wr_addr` equal to the pointer and `wr_data` equal to {upper, lower}. Every received data byte is acknowledged, and `wr_stb` and `rd_req` are never high together.
- R6: After each complete 16-bit word, written or read, the pointer increases by one and wraps at 2^REG_AW.
- R7: An upper byte followed by a stop or a repeated start produces no `wr_stb` and leaves the pointer unchanged.
- R8: In a read, `rd_req` pulses for one cycle with `rd_addr` equal to the pointer, and `rd_data` must be valid in the cycle after the pulse. The word goes out upper byte first, MSB first. The slave changes its drive only while the synchronized SCL is low.
- R9: A host acknowledge (SDA low on the ninth clock) after a transmitted byte continues the read; after a lower byte it continues with the next register. A host no-acknowledge releases SDA, and the slave drives nothing until the next start.
- R10: A repeated start returns the slave to address matching and releases SDA. The pointer survives it, so a write of the pointer followed by a repeated start and a read returns that register.
- R11: When the address does not match, the slave never drives SDA and issues no strobe or request until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_drive_low | output | 1 | 1 pulls the data line low; 0 releases it |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | REG_AW | Register index of the write |
| wr_data | output | 16 | Word to write, upper byte from the first transfer |
| rd_req | output | 1 | One-cycle read request to the register bank |
| rd_addr | output | REG_AW | Register index of the read |
| rd_data | input | 16 | Read word, valid the cycle after `rd_req` |

## Verification
The bench builds the slave with `REG_AW` = 4. With only sixteen registers, a two-word burst starting at pointer 15 crosses the wrap to register 0, both on writes and on reads. `SYNC_STAGES` = 3 lengthens the path from an SCL fall to the slave's drive change. This checks that acknowledge and data bits still settle well inside the low phase. `DEV_ADDR` = 0x2C is set so that the neighbouring address 0x2D gives a mismatch that differs in one bit only.

// File: rtl/twr_pkg.sv
package twr_pkg;

   localparam int unsigned TWR_BYTE_W = 8;
   localparam int unsigned TWR_WORD_W = 2 * TWR_BYTE_W;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_MACK
   } twr_state_e;

   typedef enum logic [1:0] {
      BK_DEV,
      BK_PTR,
      BK_HI,
      BK_LO
   } twr_kind_e;

endpackage

// File: rtl/twr_sync.sv
module twr_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("twr_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("twr_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/twr_bus_events.sv
module twr_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   logic scl_held_high;
   assign scl_held_high = scl_s & scl_q;

   assign scl_rise  =  scl_s & ~scl_q;
   assign scl_fall  = ~scl_s &  scl_q;
   assign start_det = scl_held_high &  sda_q & ~sda_s;
   assign stop_det  = scl_held_high & ~sda_q &  sda_s;

endmodule

// File: rtl/twr_regslave.sv
module twr_regslave
   import twr_pkg::*;
#(
   parameter int unsigned DEV_ADDR    = 'h48,
   parameter int unsigned REG_AW      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_in,
   input  logic                  sda_in,
   output logic                  sda_drive_low,
   output logic                  wr_stb,
   output logic [REG_AW-1:0]     wr_addr,
   output logic [TWR_WORD_W-1:0] wr_data,
   output logic                  rd_req,
   output logic [REG_AW-1:0]     rd_addr,
   input  logic [TWR_WORD_W-1:0] rd_data
);

   localparam int unsigned BITS_LAST = TWR_BYTE_W - 1;
   localparam int unsigned CNT_W     = $clog2(TWR_BYTE_W + 1);
   localparam logic [6:0]  DEV7      = DEV_ADDR[6:0];

   if (DEV_ADDR > 127) begin : g_bad_dev
      $error("twr_regslave: DEV_ADDR must fit in 7 bits");
   end
   if (REG_AW < 1 || REG_AW > 16) begin : g_bad_aw
      $error("twr_regslave: REG_AW must lie in 1..16");
   end

   // ---------------- synchronizer and bus events ----------------
   logic [1:0] bus_s;
   logic       scl_s;
   logic       sda_s;
   logic       scl_rise;
   logic       scl_fall;
   logic       start_det;
   logic       stop_det;

   twr_sync #(
      .WIDTH  (2),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({scl_in, sda_in}),
      .dout  (bus_s)
   );

   assign scl_s = bus_s[1];
   assign sda_s = bus_s[0];

   twr_bus_events u_events (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   // ---------------- state ----------------
   twr_state_e              state;
   twr_kind_e               kind;
   logic                    rw_q;
   logic [TWR_BYTE_W-1:0]   shreg;
   logic [CNT_W-1:0]        bitcnt;
   logic [REG_AW-1:0]       ptr;
   logic [TWR_BYTE_W-1:0]   hi_q;
   logic [TWR_WORD_W-1:0]   rd_word;
   logic                    rd_pend;
   logic                    drive_q;
   logic                    mack_q;
   logic                    wr_stb_q;
   logic [REG_AW-1:0]       wr_addr_q;
   logic [TWR_WORD_W-1:0]   wr_data_q;
   logic                    rd_req_q;
   logic [REG_AW-1:0]       rd_addr_q;

   // pointer load from a received byte: width variant chosen at elaboration
   logic [REG_AW-1:0] ptr_load;
   if (REG_AW >= TWR_BYTE_W) begin : g_ptr_wide
      assign ptr_load = {{(REG_AW - TWR_BYTE_W){1'b0}}, shreg};
   end else begin : g_ptr_narrow
      logic [TWR_BYTE_W-REG_AW-1:0] ptr_spare;
      assign ptr_load  = shreg[REG_AW-1:0];
      assign ptr_spare = shreg[TWR_BYTE_W-1:REG_AW];
   end

   logic [REG_AW-1:0] ptr_next;
   assign ptr_next = ptr + REG_AW'(1);

   logic byte_done;
   assign byte_done = scl_fall && (bitcnt == CNT_W'(TWR_BYTE_W));

   logic tx_last;
   assign tx_last = (bitcnt == CNT_W'(BITS_LAST));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         kind      <= BK_DEV;
         rw_q      <= 1'b0;
         shreg     <= '0;
         bitcnt    <= '0;
         ptr       <= '0;
         hi_q      <= '0;
         rd_word   <= '0;
         rd_pend   <= 1'b0;
         drive_q   <= 1'b0;
         mack_q    <= 1'b0;
         wr_stb_q  <= 1'b0;
         wr_addr_q <= '0;
         wr_data_q <= '0;
         rd_req_q  <= 1'b0;
         rd_addr_q <= '0;
      end else begin
         wr_stb_q <= 1'b0;
         rd_req_q <= 1'b0;
         rd_pend  <= rd_req_q;
         if (rd_pend) rd_word <= rd_data;

         if (start_det) begin
            state   <= ST_RX;
            kind    <= BK_DEV;
            bitcnt  <= '0;
            drive_q <= 1'b0;
         end else if (stop_det) begin
            state   <= ST_IDLE;
            drive_q <= 1'b0;
         end else begin
            unique case (state)
               ST_IDLE: begin
                  drive_q <= 1'b0;
               end

               ST_RX: begin
                  if (scl_rise) begin
                     shreg  <= {shreg[TWR_BYTE_W-2:0], sda_s};
                     bitcnt <= bitcnt + CNT_W'(1);
                  end else if (byte_done) begin
                     unique case (kind)
                        BK_DEV: begin
                           if (shreg[TWR_BYTE_W-1:1] == DEV7) begin
                              drive_q <= 1'b1;
                              state   <= ST_ACK;
                              rw_q    <= shreg[0];
                              if (shreg[0]) begin
                                 kind      <= BK_HI;
                                 rd_req_q  <= 1'b1;
                                 rd_addr_q <= ptr;
                              end else begin
                                 kind <= BK_PTR;
                              end
                           end else begin
                              state <= ST_IDLE;
                           end
                        end
                        BK_PTR: begin
                           ptr     <= ptr_load;
                           drive_q <= 1'b1;
                           state   <= ST_ACK;
                           kind    <= BK_HI;
                        end
                        BK_HI: begin
                           hi_q    <= shreg;
                           drive_q <= 1'b1;
                           state   <= ST_ACK;
                           kind    <= BK_LO;
                        end
                        BK_LO: begin
                           wr_stb_q  <= 1'b1;
                           wr_addr_q <= ptr;
                           wr_data_q <= {hi_q, shreg};
                           ptr       <= ptr_next;
                           drive_q   <= 1'b1;
                           state     <= ST_ACK;
                           kind      <= BK_HI;
                        end
                        default: state <= ST_IDLE;
                     endcase
                  end
               end

               ST_ACK: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (rw_q) begin
                        state   <= ST_TX;
                        shreg   <= rd_word[TWR_WORD_W-1:TWR_BYTE_W];
                        drive_q <= ~rd_word[TWR_WORD_W-1];
                     end else begin
                        state   <= ST_RX;
                        drive_q <= 1'b0;
                     end
                  end
               end

               ST_TX: begin
                  if (scl_fall) begin
                     if (tx_last) begin
                        drive_q <= 1'b0;
                        state   <= ST_MACK;
                        if (kind == BK_LO) begin
                           ptr       <= ptr_next;
                           rd_req_q  <= 1'b1;
                           rd_addr_q <= ptr_next;
                        end
                     end else begin
                        bitcnt  <= bitcnt + CNT_W'(1);
                        shreg   <= {shreg[TWR_BYTE_W-2:0], 1'b0};
                        drive_q <= ~shreg[TWR_BYTE_W-2];
                     end
                  end
               end

               ST_MACK: begin
                  if (scl_rise) begin
                     mack_q <= ~sda_s;
                  end else if (scl_fall) begin
                     if (mack_q) begin
                        state  <= ST_TX;
                        bitcnt <= '0;
                        if (kind == BK_HI) begin
                           kind    <= BK_LO;
                           shreg   <= rd_word[TWR_BYTE_W-1:0];
                           drive_q <= ~rd_word[TWR_BYTE_W-1];
                        end else begin
                           kind    <= BK_HI;
                           shreg   <= rd_word[TWR_WORD_W-1:TWR_BYTE_W];
                           drive_q <= ~rd_word[TWR_WORD_W-1];
                        end
                     end else begin
                        state   <= ST_IDLE;
                        drive_q <= 1'b0;
                     end
                  end
               end

               default: begin
                  state   <= ST_IDLE;
                  drive_q <= 1'b0;
               end
            endcase
         end
      end
   end

   assign sda_drive_low = drive_q;
   assign wr_stb        = wr_stb_q;
   assign wr_addr       = wr_addr_q;
   assign wr_data       = wr_data_q;
   assign rd_req        = rd_req_q;
   assign rd_addr       = rd_addr_q;

endmodule

// File: rtl/twr_regslave_chk.sv
module twr_regslave_chk #(
   parameter int unsigned REG_AW = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_lvl,
   input logic              start_det,
   input logic              stop_det,
   input logic              sda_drive_low,
   input logic              wr_stb,
   input logic [REG_AW-1:0] wr_addr,
   input logic              rd_req
);

   logic              seq_valid;
   logic [REG_AW-1:0] last_addr;
   logic [REG_AW-1:0] want_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_valid <= 1'b0;
         last_addr <= '0;
      end else if (start_det || stop_det) begin
         seq_valid <= 1'b0;
      end else if (wr_stb) begin
         seq_valid <= 1'b1;
         last_addr <= wr_addr;
      end
   end

   always_comb want_addr = last_addr + REG_AW'(1);

   // R1: outputs quiet out of reset
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (!sda_drive_low && !wr_stb && !rd_req));

   // R5: write strobe lasts one cycle
   p_wr_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);

   // R5: never a write and a read request together
   p_wr_rd_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_stb && rd_req));

   // R6: successive words of one transaction go to consecutive registers
   p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && seq_valid) |-> (wr_addr == want_addr));

   // R8: read request lasts one cycle
   p_rd_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req);

   // R8: drive changes only while the bus clock is low
   p_drive_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_drive_low) |-> !scl_lvl);

   // R10: start or stop releases the data line
   p_release_cond_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (start_det || stop_det) |=> !sda_drive_low);

endmodule

bind twr_regslave twr_regslave_chk #(
   .REG_AW (REG_AW)
) u_twr_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .scl_lvl       (scl_s),
   .start_det     (start_det),
   .stop_det      (stop_det),
   .sda_drive_low (sda_drive_low),
   .wr_stb        (wr_stb),
   .wr_addr       (wr_addr),
   .rd_req        (rd_req)
);

// File: tb/test_twr_regslave.sv
module test_twr_regslave;

   localparam int unsigned AW   = 4;
   localparam int unsigned DEV  = 'h2C;
   localparam int unsigned SYNC = 3;
   localparam int unsigned Q    = 6;
   localparam int unsigned NREG = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          scl_m = 1'b1;
   logic          sda_m = 1'b1;
   logic          sda_in;
   logic          sda_drive_low;
   logic          wr_stb;
   logic [AW-1:0] wr_addr;
   logic [15:0]   wr_data;
   logic          rd_req;
   logic [AW-1:0] rd_addr;
   logic [15:0]   rd_data = '0;

   always #2 clk = ~clk;

   assign sda_in = sda_m & ~sda_drive_low;

   twr_regslave #(
      .DEV_ADDR    (DEV),
      .REG_AW      (AW),
      .SYNC_STAGES (SYNC)
   ) i_twr_regslave (
      .clk           (clk),
      .rst_n         (rst_n),
      .scl_in        (scl_m),
      .sda_in        (sda_in),
      .sda_drive_low (sda_drive_low),
      .wr_stb        (wr_stb),
      .wr_addr       (wr_addr),
      .wr_data       (wr_data),
      .rd_req        (rd_req),
      .rd_addr       (rd_addr),
      .rd_data       (rd_data)
   );

   // register bank fed by the block's own strobes
   logic [15:0] bank_mem [NREG];
   // reference model of what the bank should hold
   logic [15:0] ref_mem  [NREG];
   logic [AW+15:0] exp_q [$];

   int n_checks = 0;
   int n_err    = 0;
   int cycles   = 0;

   initial begin
      for (int i = 0; i < int'(NREG); i++) begin
         bank_mem[i] = '0;
         ref_mem[i]  = '0;
      end
   end

   always @(posedge clk) begin
      if (wr_stb) bank_mem[wr_addr] <= wr_data;
      if (rd_req) rd_data <= bank_mem[rd_addr];
   end

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
   endtask

   // per-clock comparison of write strobes against the reference queue (R5, R7, R11)
   always @(negedge clk) begin
      cycles++;
      if (rst_n && wr_stb) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R7/R11 unexpected wr_stb", {12'h0, wr_addr, wr_data}, 32'h0);
         end else begin
            logic [AW+15:0] e;
            e = exp_q.pop_front();
            check({wr_addr, wr_data} == e, "R5/R6 write word",
                  32'({wr_addr, wr_data}), 32'(e));
         end
      end
      if (cycles > 150000) begin
         check(1'b0, "watchdog", 32'(cycles), 32'd150000);
         finish_run();
      end
   end

   task automatic wait_q(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_cycle(input logic b, output logic seen);
      wait_q(Q);
      sda_m = b;
      wait_q(Q);
      scl_m = 1'b1;
      wait_q(Q);
      seen = sda_in;
      wait_q(Q);
      scl_m = 1'b0;
   endtask

   task automatic bus_start();
      wait_q(Q);
      sda_m = 1'b1;
      wait_q(Q);
      scl_m = 1'b1;
      wait_q(2 * Q);
      sda_m = 1'b0;
      wait_q(2 * Q);
      scl_m = 1'b0;
   endtask

   task automatic bus_stop();
      wait_q(Q);
      sda_m = 1'b0;
      wait_q(Q);
      scl_m = 1'b1;
      wait_q(2 * Q);
      sda_m = 1'b1;
      wait_q(2 * Q);
   endtask

   task automatic send_byte(input logic [7:0] b, input logic exp_nack, input string req);
      logic seen;
      for (int i = 7; i >= 0; i--) bit_cycle(b[i], seen);
      bit_cycle(1'b1, seen);
      check(seen == exp_nack, req, 32'(seen), 32'(exp_nack));
   endtask

   task automatic recv_byte(input logic [7:0] exp, input logic host_ack, input string req);
      logic [7:0] got;
      logic       seen;
      for (int i = 7; i >= 0; i--) begin
         bit_cycle(1'b1, seen);
         got[i] = seen;
      end
      bit_cycle(~host_ack, seen);
      check(got == exp, req, 32'(got), 32'(exp));
   endtask

   task automatic push_wr(input logic [AW-1:0] a, input logic [15:0] d);
      exp_q.push_back({a, d});
      ref_mem[a] = d;
   endtask

   localparam logic [7:0] ADDR_W  = 8'((DEV << 1) | 0);
   localparam logic [7:0] ADDR_R  = 8'((DEV << 1) | 1);
   localparam logic [7:0] OTHER_W = 8'(((DEV + 1) << 1) | 0);

   task automatic write_words(input logic [7:0] p, input logic [15:0] w0,
                              input logic [15:0] w1);
      bus_start();
      send_byte(ADDR_W, 1'b0, "R2/R3 address ack");
      send_byte(p, 1'b0, "R4 pointer ack");
      push_wr(AW'(p), w0);
      push_wr(AW'(p + 8'd1), w1);
      send_byte(w0[15:8], 1'b0, "R5 upper ack");
      send_byte(w0[7:0],  1'b0, "R5 lower ack");
      send_byte(w1[15:8], 1'b0, "R5 upper ack");
      send_byte(w1[7:0],  1'b0, "R5 lower ack");
      bus_stop();
   endtask

   task automatic read_words(input logic [7:0] p, input int nwords, input string req);
      logic [AW-1:0] a;
      bus_start();
      send_byte(ADDR_W, 1'b0, "R3 address ack");
      send_byte(p, 1'b0, "R4 pointer ack");
      bus_start();
      send_byte(ADDR_R, 1'b0, "R10 read address ack after repeated start");
      a = AW'(p);
      for (int k = 0; k < nwords; k++) begin
         recv_byte(ref_mem[a][15:8], 1'b1, req);
         recv_byte(ref_mem[a][7:0], k != nwords - 1, req);
         a = a + AW'(1);
      end
   endtask

   initial begin
      logic seen;
      wait_q(3);
      check(sda_drive_low == 1'b0, "R1 drive in reset", 32'(sda_drive_low), 0);
      check(wr_stb == 1'b0, "R1 wr_stb in reset", 32'(wr_stb), 0);
      rst_n = 1'b1;
      wait_q(4);
      check(!sda_drive_low && !wr_stb && !rd_req, "R1 quiet after reset",
            32'({sda_drive_low, wr_stb, rd_req}), 0);

      // R4 R5 R6: two words from pointer 3
      write_words(8'h03, 16'hA55A, 16'h1234);
      // R6 wrap: pointer 15 then 0
      write_words(8'h0F, 16'hBEEF, 16'h0F0F);
      write_words(8'h06, 16'h6666, 16'h7777);

      // R7: upper byte then stop
      bus_start();
      send_byte(ADDR_W, 1'b0, "R3 address ack");
      send_byte(8'h05, 1'b0, "R4 pointer ack");
      send_byte(8'h77, 1'b0, "R7 upper ack");
      bus_stop();
      check(exp_q.size() == 0, "R7 no commit on stop", 32'(exp_q.size()), 0);

      // R7 R10: upper byte then repeated start; pointer kept at 6
      bus_start();
      send_byte(ADDR_W, 1'b0, "R3 address ack");
      send_byte(8'h06, 1'b0, "R4 pointer ack");
      send_byte(8'h99, 1'b0, "R7 upper ack");
      bus_start();
      send_byte(ADDR_R, 1'b0, "R10 address ack");
      recv_byte(8'h66, 1'b1, "R7 R10 pointer kept, upper byte");
      recv_byte(8'h66, 1'b0, "R7 R10 pointer kept, lower byte");
      bus_stop();

      // R11: neighbouring address is ignored
      bus_start();
      send_byte(OTHER_W, 1'b1, "R11 mismatch nack");
      send_byte(8'h03, 1'b1, "R11 no ack on pointer");
      send_byte(8'h11, 1'b1, "R11 no ack on data");
      send_byte(8'h22, 1'b1, "R11 no ack on data");
      bus_stop();

      // R8 R9: two-word burst read
      read_words(8'h03, 2, "R8 R9 read data");
      bit_cycle(1'b1, seen);
      check(seen == 1'b1, "R9 released after nack", 32'(seen), 1);
      bit_cycle(1'b1, seen);
      check(seen == 1'b1, "R9 released after nack", 32'(seen), 1);
      bus_stop();

      // R6 R8: read burst across the wrap
      read_words(8'h0F, 2, "R6 R8 wrap read");
      bus_stop();

      // R7: register 5 still zero
      read_words(8'h05, 1, "R7 partial left register unchanged");
      bus_stop();

      wait_q(10);
      check(exp_q.size() == 0, "R5 all writes seen", 32'(exp_q.size()), 0);
      finish_run();
   end

endmodule